// File: doc/BRIEF.md
# Obstacle-Aware Zero-Flux Boundary Stage

This stage sits in a streaming grid pipeline. It receives the cells of a two-dimensional grid in raster order, one 28-bit cell word per clock, and emits a corrected copy of every cell after a fixed latency. Each word carries a signed 24-bit state value in bits 23:0 and four flag bits in bits 27:24. Bit 25 marks a frozen cell, which is an effective obstacle.

Row delay lines and a 5x5 register window give the stage each cell together with its neighbours up to two positions away along both axes. A free cell next to frozen cells is corrected so that no flux crosses the obstacle surface. The cell takes the value of the free neighbour on the side away from the obstacle. The stage does this only when that neighbour is not itself squeezed against another frozen cell. Window positions that fall outside the grid are replaced by the nearest in-grid cell, so the grid edge also behaves as a zero-flux wall.

A frame begins with a single-cycle `frame_start` pulse that comes with cell 0. The remaining cells follow on consecutive clocks with no gaps. A new pulse always restarts the scan.

Top module: `zf_boundary_stage`

## Requirements
- R1: While reset is asserted, and after reset until a frame has been started, `out_valid` stays low.
- R2: For each complete frame, `out_valid` is high for exactly ROWS*COLS consecutive cycles and the cells come out in raster order. Each result is registered on the 2*COLS+4th rising edge after the edge that sampled the input cell, which is 124 edges for 60 columns.
- R3: A cell whose frozen flag (bit 25) is 1 is output unchanged.
- R4: A free cell whose east neighbour is frozen, whose west neighbour is free and whose cell two to the west is free takes the west neighbour's value in bits 23:0. The mirror case also holds: west frozen, east free and the cell two to the east free, so the cell takes the east value.
- R5: When R4 makes no change, the same rule is applied along the column. If south is frozen and north and the cell two to the north are free, the cell takes the north value. If north is frozen and south and the cell two to the south are free, the cell takes the south value.
- R6: A free cell with frozen neighbours on both opposite sides of an axis receives no correction from that axis.
- R7: If the cell two positions away on the source side is frozen, no correction is taken from that axis.
- R8: A window position outside the grid reads as the nearest in-grid cell. A free edge cell whose inward neighbour is frozen therefore keeps its own value.
- R9: Output bits 27:24 always equal the flags of the cell being output. Only bits 23:0 can change.
- R10: A `frame_start` during a frame abandons that frame. Old-frame results due more than one edge after the edge that samples the new pulse are not output, and the new frame is timed from the new pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| frame_start | input | 1 | One-cycle pulse that comes with cell 0 of a frame |
| cell_in | input | 28 | Incoming cell word, one per clock while a frame streams in |
| out_valid | output | 1 | High when `out_cell` holds a corrected cell |
| out_cell | output | 28 | Corrected cell word in raster order |

## Verification
All corrected results appear 2*COLS+4 rising edges after their input cell is sampled. The bench computes the correction for every cell from its own copy of the frame. It files each expected word under the absolute edge index at which it is due, and compares the outputs at every falling clock edge: it checks `out_valid` on every cycle and the word whenever a result is due. A frame restarted mid-stream removes every pending expectation due more than one edge after the restarting pulse, so outputs that leak from the abandoned frame are caught in the exact cycle they would appear.

// File: rtl/zf_pkg.sv
package zf_pkg;
  // Source of the value bits for a corrected cell
  typedef enum logic [2:0] {
    SRC_SELF  = 3'd0,
    SRC_WEST  = 3'd1,
    SRC_EAST  = 3'd2,
    SRC_NORTH = 3'd3,
    SRC_SOUTH = 3'd4
  } src_e;
endpackage

// File: rtl/zf_line_delay.sv
// One grid row of delay: the output is the input seen DEPTH clocks earlier.
module zf_line_delay #(
  parameter int DEPTH = 60,
  parameter int W     = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    if (ptr_q == AW'(DEPTH - 1)) ptr_d = '0;
    else                         ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // read-before-write at the same slot gives exactly DEPTH cycles of delay
  assign dout = mem[ptr_q];

  always_ff @(posedge clk) begin
    mem[ptr_q] <= din;
  end

  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q < AW'(DEPTH));
endmodule

// File: rtl/zf_window.sv
// Builds a 5x5 window from the raster stream; exposes the cross through the centre.
module zf_window #(
  parameter int COLS = 60,
  parameter int W    = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] c_o,
  output logic [W-1:0] w1_o,
  output logic [W-1:0] w2_o,
  output logic [W-1:0] e1_o,
  output logic [W-1:0] e2_o,
  output logic [W-1:0] n1_o,
  output logic [W-1:0] n2_o,
  output logic [W-1:0] s1_o,
  output logic [W-1:0] s2_o
);
  localparam int SPAN  = 5;
  localparam int MID   = SPAN / 2;
  localparam int LINES = SPAN - 1;

  // tap[j] is the stream delayed by j rows
  logic [W-1:0] tap [SPAN];
  // win[j][d] is tap[j] delayed by d+1 clocks
  logic [W-1:0] win [SPAN][SPAN];

  assign tap[0] = din;

  for (genvar j = 1; j <= LINES; j++) begin : g_lines
    zf_line_delay #(.DEPTH(COLS), .W(W)) u_line (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (tap[j-1]),
      .dout (tap[j])
    );
  end

  for (genvar j = 0; j < SPAN; j++) begin : g_rows
    logic [W-1:0] sh [SPAN];
    always_ff @(posedge clk) begin
      sh[0] <= tap[j];
      for (int d = 1; d < SPAN; d++) sh[d] <= sh[d-1];
    end
    for (genvar d = 0; d < SPAN; d++) begin : g_cols
      assign win[j][d] = sh[d];
    end
  end

  // newest row is the southernmost; newest column is the easternmost
  assign c_o  = win[MID][MID];
  assign e1_o = win[MID][MID-1];
  assign e2_o = win[MID][MID-2];
  assign w1_o = win[MID][MID+1];
  assign w2_o = win[MID][MID+2];
  assign s1_o = win[MID-1][MID];
  assign s2_o = win[MID-2][MID];
  assign n1_o = win[MID+1][MID];
  assign n2_o = win[MID+2][MID];
endmodule

// File: rtl/zf_scan_ctrl.sv
// Tracks the grid position of the cell currently at the window centre.
module zf_scan_ctrl #(
  parameter int COLS = 60,
  parameter int ROWS = 60,
  localparam int RW  = $clog2(ROWS),
  localparam int CLW = $clog2(COLS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  output logic           ctr_vld,
  output logic [RW-1:0]  ctr_row,
  output logic [CLW-1:0] ctr_col
);
  // edges from the pulse until cell 0 sits in the window centre
  localparam int HIT = 2 * COLS + 2;
  localparam int CW  = $clog2(HIT + 1);

  logic           run_q, run_d;
  logic           vld_q, vld_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [RW-1:0]  row_q, row_d;
  logic [CLW-1:0] col_q, col_d;
  logic           en;

  assign en = frame_start | run_q;

  always_comb begin
    run_d = run_q;
    vld_d = vld_q;
    cnt_d = cnt_q;
    row_d = row_q;
    col_d = col_q;
    if (frame_start) begin
      run_d = 1'b1;
      vld_d = 1'b0;
      cnt_d = CW'(1);
      row_d = '0;
      col_d = '0;
    end else if (!vld_q) begin
      if (cnt_q == CW'(HIT)) begin
        vld_d = 1'b1;
        row_d = '0;
        col_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end else if (col_q == CLW'(COLS - 1)) begin
      col_d = '0;
      if (row_q == RW'(ROWS - 1)) begin
        vld_d = 1'b0;
        run_d = 1'b0;
      end else begin
        row_d = row_q + RW'(1);
      end
    end else begin
      col_d = col_q + CLW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      vld_q <= 1'b0;
      cnt_q <= '0;
      row_q <= '0;
      col_q <= '0;
    end else if (en) begin
      run_q <= run_d;
      vld_q <= vld_d;
      cnt_q <= cnt_d;
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign ctr_vld = vld_q;
  assign ctr_row = row_q;
  assign ctr_col = col_q;

  assert_col_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (col_q < CLW'(COLS)) && (row_q < RW'(ROWS)));

  assert_scan_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> (row_q == '0) && (col_q == '0));

  assert_restart_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !vld_q);
endmodule

// File: rtl/zf_fix.sv
// Two-stage boundary correction: stage A clamps and decides, stage B selects.
module zf_fix
  import zf_pkg::*;
#(
  parameter int COLS       = 60,
  parameter int ROWS       = 60,
  parameter int W          = 28,
  parameter int VAL_W      = 24,
  parameter int FROZEN_BIT = 25,
  localparam int RW        = $clog2(ROWS),
  localparam int CLW       = $clog2(COLS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [RW-1:0]  in_row,
  input  logic [CLW-1:0] in_col,
  input  logic [W-1:0]   in_c,
  input  logic [W-1:0]   in_w1,
  input  logic [W-1:0]   in_w2,
  input  logic [W-1:0]   in_e1,
  input  logic [W-1:0]   in_e2,
  input  logic [W-1:0]   in_n1,
  input  logic [W-1:0]   in_n2,
  input  logic [W-1:0]   in_s1,
  input  logic [W-1:0]   in_s2,
  output logic           out_vld,
  output logic [W-1:0]   out_word
);
  logic [W-1:0] w1, w2, e1, e2, n1, n2, s1, s2;
  logic         fc, fw1, fw2, fe1, fe2, fn1, fn2, fs1, fs2;
  src_e         sel_d;

  // replace out-of-grid positions with the nearest in-grid cell
  always_comb begin
    w1 = (in_col != '0)                ? in_w1 : in_c;
    w2 = (in_col >  CLW'(1))           ? in_w2 : w1;
    e1 = (in_col != CLW'(COLS - 1))    ? in_e1 : in_c;
    e2 = (in_col <  CLW'(COLS - 2))    ? in_e2 : e1;
    n1 = (in_row != '0)                ? in_n1 : in_c;
    n2 = (in_row >  RW'(1))            ? in_n2 : n1;
    s1 = (in_row != RW'(ROWS - 1))     ? in_s1 : in_c;
    s2 = (in_row <  RW'(ROWS - 2))     ? in_s2 : s1;
  end

  assign fc  = in_c[FROZEN_BIT];
  assign fw1 = w1[FROZEN_BIT];
  assign fw2 = w2[FROZEN_BIT];
  assign fe1 = e1[FROZEN_BIT];
  assign fe2 = e2[FROZEN_BIT];
  assign fn1 = n1[FROZEN_BIT];
  assign fn2 = n2[FROZEN_BIT];
  assign fs1 = s1[FROZEN_BIT];
  assign fs2 = s2[FROZEN_BIT];

  always_comb begin
    if (fc)                       sel_d = SRC_SELF;
    else if (fe1 && !fw1 && !fw2) sel_d = SRC_WEST;
    else if (fw1 && !fe1 && !fe2) sel_d = SRC_EAST;
    else if (fs1 && !fn1 && !fn2) sel_d = SRC_NORTH;
    else if (fn1 && !fs1 && !fs2) sel_d = SRC_SOUTH;
    else                          sel_d = SRC_SELF;
  end

  // stage A registers
  logic             a_vld_q;
  src_e             a_sel_q;
  logic [W-1:0]     a_c_q;
  logic [VAL_W-1:0] a_w_q, a_e_q, a_n_q, a_s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) a_vld_q <= 1'b0;
    else        a_vld_q <= in_vld;
  end

  always_ff @(posedge clk) begin
    a_sel_q <= sel_d;
    a_c_q   <= in_c;
    a_w_q   <= w1[VAL_W-1:0];
    a_e_q   <= e1[VAL_W-1:0];
    a_n_q   <= n1[VAL_W-1:0];
    a_s_q   <= s1[VAL_W-1:0];
  end

  // stage B
  logic [VAL_W-1:0] val_d;
  logic             b_vld_q;
  logic [W-1:0]     b_word_q;

  always_comb begin
    unique case (a_sel_q)
      SRC_WEST:  val_d = a_w_q;
      SRC_EAST:  val_d = a_e_q;
      SRC_NORTH: val_d = a_n_q;
      SRC_SOUTH: val_d = a_s_q;
      default:   val_d = a_c_q[VAL_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_vld_q <= 1'b0;
    else        b_vld_q <= a_vld_q;
  end

  always_ff @(posedge clk) begin
    b_word_q <= {a_c_q[W-1:VAL_W], val_d};
  end

  assign out_vld  = b_vld_q;
  assign out_word = b_word_q;

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> ##1 out_vld);

  assert_no_extra_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ##1 !out_vld);

  assert_frozen_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_c[FROZEN_BIT]) |=> ##1 (out_word == $past(in_c, 2)));

  assert_flags_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> ##1 (out_word[W-1:VAL_W] == $past(in_c[W-1:VAL_W], 2)));
endmodule

// File: rtl/zf_boundary_stage.sv
module zf_boundary_stage #(
  parameter int COLS       = 60,
  parameter int ROWS       = 60,
  parameter int W          = 28,
  parameter int VAL_W      = 24,
  parameter int FROZEN_BIT = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  logic [W-1:0] cell_in,
  output logic         out_valid,
  output logic [W-1:0] out_cell
);
  localparam int RW  = $clog2(ROWS);
  localparam int CLW = $clog2(COLS);

  logic [W-1:0]   c, w1, w2, e1, e2, n1, n2, s1, s2;
  logic           ctr_vld;
  logic [RW-1:0]  ctr_row;
  logic [CLW-1:0] ctr_col;

  zf_window #(.COLS(COLS), .W(W)) u_window (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cell_in),
    .c_o  (c),
    .w1_o (w1),
    .w2_o (w2),
    .e1_o (e1),
    .e2_o (e2),
    .n1_o (n1),
    .n2_o (n2),
    .s1_o (s1),
    .s2_o (s2)
  );

  zf_scan_ctrl #(.COLS(COLS), .ROWS(ROWS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .ctr_vld    (ctr_vld),
    .ctr_row    (ctr_row),
    .ctr_col    (ctr_col)
  );

  zf_fix #(
    .COLS(COLS), .ROWS(ROWS), .W(W), .VAL_W(VAL_W), .FROZEN_BIT(FROZEN_BIT)
  ) u_fix (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (ctr_vld),
    .in_row  (ctr_row),
    .in_col  (ctr_col),
    .in_c    (c),
    .in_w1   (w1),
    .in_w2   (w2),
    .in_e1   (e1),
    .in_e2   (e2),
    .in_n1   (n1),
    .in_n2   (n2),
    .in_s1   (s1),
    .in_s2   (s2),
    .out_vld (out_valid),
    .out_word(out_cell)
  );

  assert_idle_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/tb_zf_boundary_stage.sv
module tb_zf_boundary_stage;
  localparam int C   = 60;
  localparam int R   = 60;
  localparam int N   = C * R;
  localparam int LAT = 2 * C + 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [27:0] cell_in = '0;
  logic        out_valid;
  logic [27:0] out_cell;

  always #2 clk = ~clk;

  zf_boundary_stage dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .cell_in    (cell_in),
    .out_valid  (out_valid),
    .out_cell   (out_cell)
  );

  int          cyc = 0;
  int          vectors = 0;
  int          fails = 0;
  bit          done = 1'b0;
  string       vld_tag = "R1";
  logic [27:0] fr [N];
  logic [27:0] exp_w [int];
  string       exp_t [int];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [27:0] cell_at(int r, int c);
    int rr = (r < 0) ? 0 : ((r > R - 1) ? R - 1 : r);
    int cc = (c < 0) ? 0 : ((c > C - 1) ? C - 1 : c);
    return fr[rr * C + cc];
  endfunction

  // behavioural statement of R3..R8
  function automatic void model(int r, int c, output logic [27:0] o, output string t);
    logic [27:0] ce, w1, w2, e1, e2, n1, n2, s1, s2;
    logic [23:0] v;
    ce = cell_at(r, c);
    w1 = cell_at(r, c - 1); w2 = cell_at(r, c - 2);
    e1 = cell_at(r, c + 1); e2 = cell_at(r, c + 2);
    n1 = cell_at(r - 1, c); n2 = cell_at(r - 2, c);
    s1 = cell_at(r + 1, c); s2 = cell_at(r + 2, c);
    v = ce[23:0];
    t = "R2";
    if (ce[25]) t = "R3";
    else if (e1[25] && !w1[25] && !w2[25]) begin v = w1[23:0]; t = "R4"; end
    else if (w1[25] && !e1[25] && !e2[25]) begin v = e1[23:0]; t = "R4"; end
    else if (s1[25] && !n1[25] && !n2[25]) begin v = n1[23:0]; t = "R5"; end
    else if (n1[25] && !s1[25] && !s2[25]) begin v = s1[23:0]; t = "R5"; end
    else if ((w1[25] && e1[25]) || (n1[25] && s1[25])) t = "R6";
    else if (w1[25] || e1[25] || n1[25] || s1[25]) t = "R7";
    else if (r == 0 || c == 0 || r == R - 1 || c == C - 1) t = "R8";
    o = {ce[27:24], v};
  endfunction

  function automatic void fill(int mode);
    for (int r = 0; r < R; r++) begin
      for (int c = 0; c < C; c++) begin
        logic [27:0] x = 28'($urandom);
        bit f;
        case (mode)
          0:       f = 1'b0;
          1:       f = ($urandom % 100) < 35;
          2:       f = (r % 6 == 1) || (c % 8 == 5) || (c == C - 2) || (r == R - 2);
          default: f = ($urandom % 100) < 60;
        endcase
        x[25] = f;
        fr[r * C + c] = x;
      end
    end
  endfunction

  task automatic send_frame(int ncells, string tag);
    int p0;
    int kill [$];
    @(negedge clk);
    p0 = cyc + 1;
    // R10: pending results due after p0+1 belong to an abandoned frame
    foreach (exp_w[k]) if (k > p0 + 1) kill.push_back(k);
    foreach (kill[i]) begin
      exp_w.delete(kill[i]);
      exp_t.delete(kill[i]);
    end
    vld_tag = tag;
    for (int m = 0; m < N; m++) begin
      logic [27:0] o;
      string t;
      model(m / C, m % C, o, t);
      exp_w[p0 + m + LAT] = o;
      exp_t[p0 + m + LAT] = t;
    end
    for (int m = 0; m < ncells; m++) begin
      frame_start = (m == 0);
      cell_in     = fr[m];
      @(negedge clk);
    end
    frame_start = 1'b0;
    cell_in     = 28'($urandom);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      cell_in = 28'($urandom);
      @(negedge clk);
    end
  endtask

  // compare every cycle against the schedule
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (exp_w.exists(cyc)) begin
        if (!out_valid) begin
          fails++;
          $display("FAIL R2 (%s cell) edge %0d: out_valid actual 0 expected 1", exp_t[cyc], cyc);
        end else begin
          if (out_cell[27:24] !== exp_w[cyc][27:24]) begin
            fails++;
            $display("FAIL R9 edge %0d: flags actual %h expected %h",
                     cyc, out_cell[27:24], exp_w[cyc][27:24]);
          end
          if (out_cell[23:0] !== exp_w[cyc][23:0]) begin
            fails++;
            $display("FAIL %s edge %0d: value actual %h expected %h",
                     exp_t[cyc], cyc, out_cell[23:0], exp_w[cyc][23:0]);
          end
        end
        exp_w.delete(cyc);
        exp_t.delete(cyc);
      end else if (out_valid !== 1'b0) begin
        fails++;
        $display("FAIL %s edge %0d: out_valid actual %b expected 0", vld_tag, cyc, out_valid);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run still active, expected completion");
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset and idle before any frame
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(200);
    // R2, R8: free cells only, output equals input
    fill(0);
    send_frame(N, "R2");
    idle(LAT + 20);
    // R3..R7: sparse random obstacles
    fill(1);
    send_frame(N, "R2");
    idle(LAT + 20);
    // R8: obstacle lines beside every grid edge
    fill(2);
    send_frame(N, "R8");
    idle(LAT + 20);
    // R10: dense frame abandoned after 1000 cells, restarted at once
    fill(3);
    send_frame(1000, "R2");
    fill(3);
    send_frame(N, "R10");
    idle(LAT + 30);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule